// File: doc/BRIEF.md
# Read/Write Bus Request Arbiter

This block sits between two DMA directions and the bus interface. It decides when to raise the bus request and which direction the transfer engine runs during the next bus tenure. The read direction moves data from the bus into a local FIFO. The write direction drains a local FIFO onto the bus.

Each direction supplies an enable, a flag that says its remaining count is non-zero, a FIFO level and a threshold-select bit. Software supplies two priority bits. When a direction meets its conditions, the block registers that qualification and raises `bus_req`. When `bus_gnt` arrives, the block latches the chosen direction on `ten_wr` and holds it, with `ten_act` high, until the engine pulses `xfer_done`.

When only one priority bit is set, that bit gives fixed priority. When the two bits are equal, the grant alternates between the directions, and the read direction goes first after reset.

Top module: `rw_busreq_arb`

## Requirements
- R1: A direction whose enable input is low never causes `bus_req` to rise.
- R2: A direction whose non-zero-count flag is low never causes `bus_req` to rise.
- R3: With its deep bit at 0, the read direction qualifies when `rd_free` >= 1, and the write direction qualifies when `wr_fill` >= 1.
- R4: With its deep bit at 1, the threshold rises to `DEEP_LVL`, which defaults to 4 words, for `rd_free` or for `wr_fill`.
- R5: Qualification is sampled at a clock edge and `bus_req` follows it in the next cycle. `bus_req` is low whenever `ten_act` is high.
- R6: A clock edge with `bus_gnt` and `bus_req` both high sets `ten_act`. The same edge loads `ten_wr` with the chosen direction (0 = read, 1 = write). Both hold until the edge that samples `xfer_done`, which clears `ten_act`.
- R7: When both directions qualify and `pri_rd_first`=1, `pri_wr_first`=0, the read direction wins. With the bits swapped, the write direction wins.
- R8: When both directions qualify and the priority bits are equal, the grants alternate. The first such grant after reset goes to the read direction.
- R9: The alternation choice changes only when a tenure completes, and it then favours the direction opposite to the one just served.
- R10: While a direction's flag-clear input is high, and in the cycle after it, that direction's qualification is cleared, so it cannot raise `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_gnt | input | 1 | Bus grant for the pending request |
| xfer_done | input | 1 | Engine strobe ending the current tenure |
| rd_en | input | 1 | Read-direction mastering enable |
| rd_cnt_nz | input | 1 | Read-direction remaining count is non-zero |
| rd_free | input | LVL_W | Free words in the read-direction FIFO |
| rd_deep | input | 1 | Read-direction threshold select |
| rd_flag_clr | input | 1 | Clears read-direction qualification |
| wr_en | input | 1 | Write-direction mastering enable |
| wr_cnt_nz | input | 1 | Write-direction remaining count is non-zero |
| wr_fill | input | LVL_W | Words held in the write-direction FIFO |
| wr_deep | input | 1 | Write-direction threshold select |
| wr_flag_clr | input | 1 | Clears write-direction qualification |
| pri_rd_first | input | 1 | Read-over-write priority bit |
| pri_wr_first | input | 1 | Write-over-read priority bit |
| bus_req | output | 1 | Bus request |
| ten_act | output | 1 | A tenure is in progress |
| ten_wr | output | 1 | Direction of the tenure (0 read, 1 write) |

## Verification
The assertions assume three things about the inputs:
- `xfer_done` arrives only while a tenure is active.
- The flag-clear inputs are low during reset.
- `bus_gnt` is meaningful only while a request is pending.

The stimulus keeps to these assumptions. It raises `bus_gnt` for a single cycle only after `bus_req` has been observed. It pulses `xfer_done` only after the tenure has been seen to start. It holds every control at zero through reset.

// File: rtl/rw_busreq_arb.sv
module rw_busreq_arb #(
  parameter int LVL_W    = 4,
  parameter int DEEP_LVL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_gnt,
  input  logic             xfer_done,
  input  logic             rd_en,
  input  logic             rd_cnt_nz,
  input  logic [LVL_W-1:0] rd_free,
  input  logic             rd_deep,
  input  logic             rd_flag_clr,
  input  logic             wr_en,
  input  logic             wr_cnt_nz,
  input  logic [LVL_W-1:0] wr_fill,
  input  logic             wr_deep,
  input  logic             wr_flag_clr,
  input  logic             pri_rd_first,
  input  logic             pri_wr_first,
  output logic             bus_req,
  output logic             ten_act,
  output logic             ten_wr
);

  localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);
  localparam logic [LVL_W-1:0] LVL_DEEP = LVL_W'(DEEP_LVL);

  logic rd_qr, wr_qr, alt_wr;

  wire rd_lvl_ok = rd_free >= (rd_deep ? LVL_DEEP : LVL_ONE);
  wire wr_lvl_ok = wr_fill >= (wr_deep ? LVL_DEEP : LVL_ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_qr <= 1'b0;
      wr_qr <= 1'b0;
    end else begin
      rd_qr <= !rd_flag_clr && rd_en && rd_cnt_nz && rd_lvl_ok;
      wr_qr <= !wr_flag_clr && wr_en && wr_cnt_nz && wr_lvl_ok;
    end
  end

  wire fixed_pri = pri_rd_first ^ pri_wr_first;
  wire pick_wr   = (rd_qr && wr_qr) ? (fixed_pri ? pri_wr_first : alt_wr) : wr_qr;

  assign bus_req = !ten_act && (rd_qr || wr_qr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ten_act <= 1'b0;
      ten_wr  <= 1'b0;
      alt_wr  <= 1'b0;
    end else if (ten_act) begin
      if (xfer_done) begin
        ten_act <= 1'b0;
        alt_wr  <= !ten_wr;
      end
    end else if (bus_req && bus_gnt) begin
      ten_act <= 1'b1;
      ten_wr  <= pick_wr;
    end
  end

  AST_RD_QUAL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    rd_qr |-> $past(rd_en && rd_cnt_nz)); // R1
  AST_WR_QUAL_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_qr |-> $past(wr_cnt_nz && wr_en)); // R2
  AST_QUIET_IN_TENURE: assert property (@(posedge clk) disable iff (!rst_n)
    ten_act |-> !bus_req); // R5
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ten_act && $past(ten_act)) |-> $stable(ten_wr)); // R6
  AST_END_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ten_act) |-> $past(xfer_done)); // R6
  AST_FIXED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ten_act) && $past(pri_rd_first && !pri_wr_first && rd_qr)) |-> !ten_wr); // R7
  AST_FIXED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ten_act) && $past(pri_wr_first && !pri_rd_first && wr_qr)) |-> ten_wr); // R7
  AST_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_flag_clr) |-> !rd_qr); // R10
  AST_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_flag_clr) |-> !wr_qr); // R10

endmodule

// File: tb/tb_rw_busreq_arb.sv
module tb_rw_busreq_arb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, bus_gnt, xfer_done;
  logic rd_en, rd_cnt_nz, rd_deep, rd_flag_clr;
  logic wr_en, wr_cnt_nz, wr_deep, wr_flag_clr;
  logic [3:0] rd_free, wr_fill;
  logic pri_rd_first, pri_wr_first;
  logic bus_req, ten_act, ten_wr;

  rw_busreq_arb dut (.*);

  int checks = 0;
  int errors = 0;
  logic  exp_q[$];
  string tag_q[$];
  logic  mon_prev = 1'b0;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FIFO-arb FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && ten_act === 1'b1 && !mon_prev) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL monitor: unexpected tenure, got ten_wr=%b expected none", ten_wr);
      end else begin
        string t;
        logic e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, ten_wr, e);
      end
    end
    mon_prev = ten_act;
  end

  task automatic set_rd(input logic en, input logic nz, input logic [3:0] lvl, input logic dp);
    rd_en = en; rd_cnt_nz = nz; rd_free = lvl; rd_deep = dp;
  endtask

  task automatic set_wr(input logic en, input logic nz, input logic [3:0] lvl, input logic dp);
    wr_en = en; wr_cnt_nz = nz; wr_fill = lvl; wr_deep = dp;
  endtask

  task automatic step_req(input string tag, input logic exp);
    @(negedge clk);
    check(tag, bus_req, exp);
  endtask

  task automatic tenure(input string tag, input logic exp);
    check({tag, " req before grant"}, bus_req, 1'b1);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    check("R6 tenure active", ten_act, 1'b1);
    check("R5 req low in tenure", bus_req, 1'b0);
    pri_rd_first = ~pri_rd_first;
    repeat (2) @(negedge clk);
    pri_rd_first = ~pri_rd_first;
    check("R6 direction held", ten_wr, exp);
    check("R6 still active", ten_act, 1'b1);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check("R6 ends on done", ten_act, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_gnt = 1'b0; xfer_done = 1'b0;
    rd_flag_clr = 1'b0; wr_flag_clr = 1'b0;
    pri_rd_first = 1'b0; pri_wr_first = 1'b0;
    set_rd(0, 0, 4'd0, 0);
    set_wr(0, 0, 4'd0, 0);
    repeat (3) @(negedge clk);
    check("reset bus_req", bus_req, 1'b0);
    check("reset ten_act", ten_act, 1'b0);
    rst_n = 1'b1;

    set_rd(0, 1, 4'd8, 0); set_wr(0, 1, 4'd8, 0);
    step_req("R1 disabled", 1'b0);
    step_req("R1 disabled hold", 1'b0);
    set_rd(1, 0, 4'd8, 0); set_wr(1, 0, 4'd8, 0);
    step_req("R2 zero count", 1'b0);
    set_wr(0, 0, 4'd0, 0);
    set_rd(1, 1, 4'd0, 0);
    step_req("R3 read none free", 1'b0);
    set_rd(1, 1, 4'd1, 0);
    step_req("R3 read one free", 1'b1);
    set_rd(1, 1, 4'd3, 1);
    step_req("R4 read three deep", 1'b0);
    set_rd(1, 1, 4'd4, 1);
    step_req("R4 read four deep", 1'b1);
    set_rd(0, 1, 4'd4, 1);
    set_wr(1, 1, 4'd0, 0);
    step_req("R3 write empty", 1'b0);
    set_wr(1, 1, 4'd1, 0);
    step_req("R3 write one held", 1'b1);
    set_wr(1, 1, 4'd3, 1);
    step_req("R4 write three deep", 1'b0);
    set_wr(1, 1, 4'd4, 1);
    step_req("R4 write four deep", 1'b1);

    set_rd(1, 1, 4'd8, 0); set_wr(1, 1, 4'd8, 0);
    @(negedge clk);
    tenure("R8 first alt read", 1'b0);
    tenure("R8 alt write", 1'b1);
    tenure("R8 alt read", 1'b0);

    set_rd(0, 1, 4'd8, 0);
    @(negedge clk);
    tenure("R9 single write", 1'b1);
    set_rd(1, 1, 4'd8, 0);
    @(negedge clk);
    tenure("R9 after write read", 1'b0);

    pri_rd_first = 1'b1; pri_wr_first = 1'b0;
    @(negedge clk);
    tenure("R7 read fixed a", 1'b0);
    tenure("R7 read fixed b", 1'b0);
    pri_rd_first = 1'b0; pri_wr_first = 1'b1;
    @(negedge clk);
    tenure("R7 write fixed a", 1'b1);
    tenure("R7 write fixed b", 1'b1);
    pri_rd_first = 1'b1;
    @(negedge clk);
    tenure("R8 both set read", 1'b0);
    tenure("R8 both set write", 1'b1);
    pri_rd_first = 1'b0; pri_wr_first = 1'b0;

    set_wr(0, 1, 4'd8, 0);
    @(negedge clk);
    check("R10 before clear", bus_req, 1'b1);
    rd_flag_clr = 1'b1;
    step_req("R10 during clear", 1'b0);
    rd_flag_clr = 1'b0;
    check("R10 after clear", bus_req, 1'b0);
    step_req("R10 recovered", 1'b1);

    set_rd(0, 1, 4'd8, 0); set_wr(1, 1, 4'd8, 0);
    @(negedge clk);
    wr_flag_clr = 1'b1;
    step_req("R10 write clear", 1'b0);
    wr_flag_clr = 1'b0;
    step_req("R10 write recovered", 1'b1);

    repeat (2) @(negedge clk);
    check("monitor queue drained", exp_q.size() == 0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule